// File: doc/BRIEF.md
# Bit-serial 16x16 data router

This block moves single bits from sixteen input shift registers into sixteen output shift registers over one shared one-bit bus. The sources are organised as two groups of eight, each behind its own eight-way selector. A 4-bit source address enables exactly one selector and picks one register inside its group. That register's most significant bit goes onto the bus. A 4-bit destination address then steers the bus bit into one output register. That register shifts left and takes the bit in at its least significant end.

In manual operation the source address, destination address, transfer strobe, input shift strobe and parallel load are driven freely every cycle. Any routing pattern can be built this way, whether the data is sliced horizontally, vertically or intermixed. A sweep mode automates the transposing pattern. Each bit position takes sixteen transfer cycles that visit every source in ascending order. All of those bits go into the output register numbered after that position, and one input shift follows. After all `W` positions, output register p holds bit slice p of the sixteen inputs. A done flag then reports completion.

Top module: `slice_router`

## Requirements
- R1: After reset every output register reads zero and `busy` and `done` are low.
- R2: A transfer reads bit `W-1` (the current MSB) of source register `srcAddr`. `srcAddr[3]` picks the group (0 selects sources 0 to 7, 1 selects sources 8 to 15) and `srcAddr[2:0]` picks the register inside that group.
- R3: During a transfer exactly one group selector drives the bus. With no transfer, no selector drives it.
- R4: On a transfer, output register `dstAddr` becomes `{old[14:0], busBit}` with no inversion, and the other fifteen output registers hold. Output register d appears at `outData[d*16 +: 16]`.
- R5: In a cycle with no transfer, every output register holds its value.
- R6: `loadEn` writes `loadData[i*W +: W]` into input register i. `shiftEn` shifts every input register left by one and fills with zero. If both are asserted, the load wins.
- R7: When a transfer and an input shift fall in the same cycle, the bus carries the MSB from before the shift.
- R8: A `sweepStart` seen while idle runs exactly 16*W busy cycles. Position p (0 to W-1) moves sources 0 to 15 in turn into output register p and then shifts the inputs. The result is `out[p][15-s] = in[s][W-1-p]`.
- R9: `done` rises in the same cycle that `busy` falls and stays high until the next sweep starts. `busy` and `done` are never high together.
- R10: While `busy` is high, the manual `loadEn`, `shiftEn`, `xferEn`, `srcAddr`, `dstAddr` and `sweepStart` inputs have no effect.
- R11: A sweep leaves output registers W to 15 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| loadEn | input | 1 | Parallel load of all input registers |
| loadData | input | 16*W | Load value, register i at bits i*W +: W |
| shiftEn | input | 1 | Shift all input registers left by one |
| xferEn | input | 1 | Manual transfer strobe |
| srcAddr | input | 4 | Source register address |
| dstAddr | input | 4 | Destination register address |
| sweepStart | input | 1 | Start a transpose sweep |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | Last sweep completed |
| outData | output | 256 | Output registers, register d at bits d*16 +: 16 |

## Verification
Two pairs of operations can collide in one cycle. A transfer can coincide with an input shift, and a parallel load can coincide with a shift. Both collisions are provoked directly in manual mode by asserting both strobes in the same cycle. For the first pair, the destination's new LSB must equal the source MSB from before the shift. A follow-up transfer from the same source must then show the shifted value. For the second pair, a transfer after the collision must expose the freshly loaded MSB rather than a shifted one.

// File: rtl/slice_router_pkg.sv
package slice_router_pkg;
  localparam int GROUP_SIZE = 8;
  localparam int NUM_GROUPS = 2;
  localparam int NUM_REG    = GROUP_SIZE * NUM_GROUPS;
  localparam int ADDR_W     = $clog2(NUM_REG);
  localparam int SEL_W      = $clog2(GROUP_SIZE);
  localparam int GRP_W      = ADDR_W - SEL_W;

  typedef struct packed {
    logic              load;
    logic              xfer;
    logic              shift;
    logic [ADDR_W-1:0] src;
    logic [ADDR_W-1:0] dst;
  } strobes_t;
endpackage

// File: rtl/slice_router_sel.sv
module slice_router_sel
  import slice_router_pkg::*;
(
  input  logic [GROUP_SIZE-1:0] msbs,
  input  logic [SEL_W-1:0]      sel,
  input  logic                  enable,
  output logic                  drive,
  output logic                  bitOut
);
  // a disabled selector contributes 0 to the wired-OR bus
  always_comb begin
    drive  = enable;
    bitOut = enable ? msbs[sel] : 1'b0;
  end
endmodule

// File: rtl/slice_router_dp.sv
module slice_router_dp
  import slice_router_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobes_t                strobes,
  input  logic [NUM_REG*W-1:0]    loadData,
  output logic [NUM_REG*NUM_REG-1:0] outData,
  output logic                    busBit,
  output logic [NUM_GROUPS-1:0]   grpDrive
);
  logic [W-1:0]          inRegs  [NUM_REG];
  logic [NUM_REG-1:0]    outRegs [NUM_REG];
  logic [NUM_REG-1:0]    msbVec;
  logic [NUM_GROUPS-1:0] grpBits;

  for (genvar i = 0; i < NUM_REG; i++) begin : g_in
    assign msbVec[i] = inRegs[i][W-1];
    always_ff @(posedge clk) begin
      if (!rstN)              inRegs[i] <= '0;
      else if (strobes.load)  inRegs[i] <= loadData[i*W +: W];
      else if (strobes.shift) inRegs[i] <= {inRegs[i][W-2:0], 1'b0};
    end
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_sel
    logic grpEn;
    assign grpEn = strobes.xfer && (strobes.src[ADDR_W-1 -: GRP_W] == GRP_W'(g));
    slice_router_sel u_sel (
      .msbs   (msbVec[g*GROUP_SIZE +: GROUP_SIZE]),
      .sel    (strobes.src[SEL_W-1:0]),
      .enable (grpEn),
      .drive  (grpDrive[g]),
      .bitOut (grpBits[g])
    );
  end

  assign busBit = |grpBits;

  for (genvar d = 0; d < NUM_REG; d++) begin : g_out
    always_ff @(posedge clk) begin
      if (!rstN)
        outRegs[d] <= '0;
      else if (strobes.xfer && strobes.dst == ADDR_W'(d))
        outRegs[d] <= {outRegs[d][NUM_REG-2:0], busBit};
    end
    assign outData[d*NUM_REG +: NUM_REG] = outRegs[d];
  end
endmodule

// File: rtl/slice_router_ctrl.sv
module slice_router_ctrl
  import slice_router_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sweepStart,
  input  logic              loadEn,
  input  logic              xferEn,
  input  logic              shiftEn,
  input  logic [ADDR_W-1:0] srcAddr,
  input  logic [ADDR_W-1:0] dstAddr,
  output strobes_t          strobes,
  output logic              busy,
  output logic              done
);
  // W must not exceed NUM_REG: sweep position doubles as destination
  localparam int POS_W = (W > 1) ? $clog2(W) : 1;

  logic [ADDR_W-1:0] srcCnt;
  logic [POS_W-1:0]  posCnt;
  logic              lastSrc;
  logic              lastPos;

  assign lastSrc = (srcCnt == ADDR_W'(NUM_REG - 1));
  assign lastPos = (posCnt == POS_W'(W - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      srcCnt <= '0;
      posCnt <= '0;
    end else if (!busy) begin
      if (sweepStart) begin
        busy   <= 1'b1;
        done   <= 1'b0;
        srcCnt <= '0;
        posCnt <= '0;
      end
    end else if (lastSrc) begin
      srcCnt <= '0;
      if (lastPos) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        posCnt <= posCnt + 1'b1;
      end
    end else begin
      srcCnt <= srcCnt + 1'b1;
    end
  end

  always_comb begin
    if (busy) begin
      strobes.load  = 1'b0;
      strobes.xfer  = 1'b1;
      strobes.shift = lastSrc;
      strobes.src   = srcCnt;
      strobes.dst   = ADDR_W'(posCnt);
    end else begin
      strobes.load  = loadEn;
      strobes.xfer  = xferEn;
      strobes.shift = shiftEn;
      strobes.src   = srcAddr;
      strobes.dst   = dstAddr;
    end
  end
endmodule

// File: rtl/slice_router.sv
module slice_router
  import slice_router_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        loadEn,
  input  logic [NUM_REG*W-1:0]        loadData,
  input  logic                        shiftEn,
  input  logic                        xferEn,
  input  logic [ADDR_W-1:0]           srcAddr,
  input  logic [ADDR_W-1:0]           dstAddr,
  input  logic                        sweepStart,
  output logic                        busy,
  output logic                        done,
  output logic [NUM_REG*NUM_REG-1:0]  outData
);
  strobes_t              strobes;
  logic                  busBit;
  logic [NUM_GROUPS-1:0] grpDrive;

  slice_router_ctrl #(.W(W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sweepStart (sweepStart),
    .loadEn     (loadEn),
    .xferEn     (xferEn),
    .shiftEn    (shiftEn),
    .srcAddr    (srcAddr),
    .dstAddr    (dstAddr),
    .strobes    (strobes),
    .busy       (busy),
    .done       (done)
  );

  slice_router_dp #(.W(W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .loadData (loadData),
    .outData  (outData),
    .busBit   (busBit),
    .grpDrive (grpDrive)
  );
endmodule

// File: rtl/slice_router_chk.sv
module slice_router_chk
  import slice_router_pkg::*;
(
  input logic                       clk,
  input logic                       rstN,
  input logic                       xferEn,
  input logic [ADDR_W-1:0]          dstAddr,
  input logic                       sweepStart,
  input logic                       busy,
  input logic                       done,
  input logic [NUM_REG*NUM_REG-1:0] outData,
  input logic                       busBit,
  input logic [NUM_GROUPS-1:0]      grpDrive
);
  // R3
  bus_single_driver_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grpDrive));

  // R3
  bus_driven_on_xfer_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy || xferEn) |-> $countones(grpDrive) == 1);

  // R4
  dst_takes_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    (xferEn && !busy) |=> outData[int'($past(dstAddr))*NUM_REG] == $past(busBit));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !xferEn) |=> $stable(outData));

  // R9
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));

  // R9
  done_at_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  // R8
  start_enters_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sweepStart && !busy) |=> busy);
endmodule

bind slice_router slice_router_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .xferEn     (xferEn),
  .dstAddr    (dstAddr),
  .sweepStart (sweepStart),
  .busy       (busy),
  .done       (done),
  .outData    (outData),
  .busBit     (busBit),
  .grpDrive   (grpDrive)
);

// File: tb/slice_router_test.sv
module slice_router_test;
  localparam int W  = 8;
  localparam int NR = 16;

  logic            clk = 1'b0;
  logic            rstN;
  logic            loadEn;
  logic [NR*W-1:0] loadData;
  logic            shiftEn;
  logic            xferEn;
  logic [3:0]      srcAddr;
  logic [3:0]      dstAddr;
  logic            sweepStart;
  logic            busy;
  logic            done;
  logic [NR*NR-1:0] outData;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  logic [W-1:0]  expIn  [NR];
  logic [NR-1:0] expOut [NR];

  always #5 clk = ~clk;

  slice_router #(.W(W)) uut (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .loadData(loadData),
    .shiftEn(shiftEn), .xferEn(xferEn), .srcAddr(srcAddr), .dstAddr(dstAddr),
    .sweepStart(sweepStart), .busy(busy), .done(done), .outData(outData)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic check(input string req, input logic [NR*NR-1:0] act,
                       input logic [NR*NR-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [NR*NR-1:0] packOut();
    logic [NR*NR-1:0] v;
    for (int d = 0; d < NR; d++) v[d*NR +: NR] = expOut[d];
    return v;
  endfunction

  task automatic idle();
    loadEn = 0; shiftEn = 0; xferEn = 0; sweepStart = 0;
    srcAddr = 0; dstAddr = 0;
  endtask

  // one manual cycle; the model follows the requirements
  task automatic step(input logic ld, input logic xf, input logic sh,
                      input logic [3:0] s, input logic [3:0] d,
                      input logic [NR*W-1:0] val);
    logic b;
    loadEn = ld; xferEn = xf; shiftEn = sh; srcAddr = s; dstAddr = d;
    loadData = val;
    @(negedge clk);
    idle();
    b = expIn[s][W-1];                                   // R7 pre-shift MSB
    if (xf) expOut[d] = {expOut[d][NR-2:0], b};
    for (int i = 0; i < NR; i++) begin
      if (ld) expIn[i] = val[i*W +: W];
      else if (sh) expIn[i] = {expIn[i][W-2:0], 1'b0};
    end
  endtask

  function automatic logic [NR*W-1:0] pattern(input int seed);
    logic [NR*W-1:0] v;
    for (int i = 0; i < NR; i++) v[i*W +: W] = W'(i * 37 + seed * 11 + 5);
    return v;
  endfunction

  task automatic testReset();
    check("R1 outData", outData, '0);
    check("R1 busy", {255'b0, busy}, '0);
    check("R1 done", {255'b0, done}, '0);
  endtask

  task automatic testManual();
    step(1, 0, 0, 0, 0, pattern(1));
    for (int s = 0; s < NR; s += 3) begin
      step(0, 1, 0, 4'(s), 4'((s * 5) % NR), '0);
      check("R2 R3 R4 manual xfer", outData, packOut());
    end
    step(0, 1, 0, 4'd8, 4'd15, '0);
    check("R2 group1 src8", outData, packOut());
    step(0, 1, 0, 4'd7, 4'd15, '0);
    check("R2 group0 src7", outData, packOut());
    for (int k = 0; k < 5; k++) step(0, 0, 0, 4'd3, 4'd3, '0);
    check("R5 hold without xfer", outData, packOut());
  endtask

  task automatic testShiftLoad();
    step(1, 0, 0, 0, 0, pattern(2));
    step(0, 0, 1, 0, 0, '0);
    step(0, 1, 0, 4'd5, 4'd2, '0);
    check("R6 shift exposes next bit", outData, packOut());
    step(1, 0, 1, 0, 0, pattern(3));
    step(0, 1, 0, 4'd12, 4'd2, '0);
    check("R6 load wins over shift", outData, packOut());
    step(0, 1, 1, 4'd9, 4'd4, '0);
    check("R7 xfer with shift uses old MSB", outData, packOut());
    step(0, 1, 0, 4'd9, 4'd4, '0);
    check("R7 following xfer sees shifted MSB", outData, packOut());
  endtask

  task automatic testSweep(input int seed);
    logic [NR*W-1:0] val;
    int cnt;
    val = pattern(seed) ^ {NR{W'(seed * 29)}};
    step(1, 0, 0, 0, 0, val);
    step(0, 1, 0, 4'd1, 4'd15, '0);                     // R11 mark reg 15
    step(0, 1, 0, 4'd2, 4'd9, '0);
    sweepStart = 1;
    @(negedge clk);
    sweepStart = 0;
    cnt = 0;
    while (busy && cnt < 1000) begin
      if (cnt >= 20 && cnt < 40) begin                  // R10 manual noise
        loadEn = 1; loadData = ~val; xferEn = 1; shiftEn = 1;
        dstAddr = 4'd15; srcAddr = 4'd3; sweepStart = 1;
      end else idle();
      cnt++;
      @(negedge clk);
    end
    idle();
    for (int p = 0; p < W; p++)
      for (int s = 0; s < NR; s++)
        expOut[p][NR-1-s] = val[s*W + (W-1-p)];
    for (int i = 0; i < NR; i++) expIn[i] = '0;
    check("R8 busy cycle count", 256'(cnt), 256'(NR * W));
    check("R9 done after sweep", {255'b0, done}, 256'd1);
    check("R8 R10 R11 transposed result", outData, packOut());
  endtask

  initial begin
    rstN = 0;
    idle();
    loadData = '0;
    for (int i = 0; i < NR; i++) begin expIn[i] = '0; expOut[i] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testManual();
    testShiftLoad();
    testSweep(4);
    sweepStart = 1;
    @(negedge clk);
    sweepStart = 0;
    check("R9 done cleared on restart", {254'b0, busy, done}, 256'b10);
    while (busy) @(negedge clk);
    testSweep(7);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule